// File: doc/BRIEF.md
# Roller Shutter Motor Interlock

This block decides, from the present state of two push buttons and two end-of-travel sensors, whether a window shutter motor should turn in the raise direction, the lower direction, or not at all. It holds no state. The motor turns only while the matching button is held. Travel stops at the sensor for that end. Any contradictory input combination turns both drives off.

The logic is a structural netlist of NOR gates with two or three inputs. Inversion is done with a two-input NOR whose inputs are tied together, so the whole block is one gate type. Each motor direction is a separate leg with one inverter and one three-input NOR. The two legs are mirror images of each other, and each leg takes the other direction's button as an inhibit. This makes the outputs mutually exclusive by construction, with no extra gating.

Top module: `shutter_interlock`

## Requirements
- R1: `drive_raise` is 1 when `btn_up`=1, `btn_down`=0 and `at_top`=0, whatever `at_bottom` is.
- R2: `drive_lower` is 1 when `btn_down`=1, `btn_up`=0 and `at_bottom`=0, whatever `at_top` is.
- R3: With neither button held, both outputs are 0 for every sensor state.
- R4: With both buttons held, both outputs are 0 for every sensor state.
- R5: Whenever `at_top`=1, `drive_raise` is 0.
- R6: Whenever `at_bottom`=1, `drive_lower` is 0.
- R7: When both sensors read 1 (sensor fault), both outputs are 0 for every button state.
- R8: `drive_raise` and `drive_lower` are never 1 at the same time, over all 16 input combinations.
- R9: The outputs depend only on the present inputs. The same input combination gives the same outputs no matter which combinations came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| btn_up | input | 1 | Raise button, 1 while pressed |
| btn_down | input | 1 | Lower button, 1 while pressed |
| at_top | input | 1 | Upper end sensor, 1 when the shutter is fully open |
| at_bottom | input | 1 | Lower end sensor, 1 when the shutter is fully closed |
| drive_raise | output | 1 | Motor command for raise direction |
| drive_lower | output | 1 | Motor command for lower direction |

## Verification
The embedded checks re-evaluate on every input change. They cover the safety properties: the two drives never assert together, an end sensor blocks its own direction, and a sensor fault, an idle button pair or a pressed button pair leaves both drives off. The permissive side of the behaviour can only be shown by the bench's directed scenarios: the motor actually runs when it should, and a sensor at one end does not block travel away from it. The same holds for the absence of memory, which the bench shows by sweeping all sixteen combinations in ascending and then descending order against a behavioural model.

// File: rtl/shutter_pkg.sv
// Package: shared constants and types for the shutter interlock.
// Assumes: gates in the netlist never exceed NOR_MAX_FANIN inputs.
package shutter_pkg;

    localparam int NOR_MAX_FANIN = 3;
    localparam int NOR_MIN_FANIN = 2;
    localparam int NUM_DIRS      = 2;

    // Index of each motor direction in the per-direction vectors.
    typedef enum logic {
        DIR_RAISE = 1'b0,
        DIR_LOWER = 1'b1
    } dir_e;

endpackage

// File: rtl/nor_gate.sv
// Module: nor_gate
// Purpose: one NOR gate of parameterised fan-in, the only primitive used.
// Assumes: FANIN is 2 or 3, as allowed by the gate library.
module nor_gate #(
    parameter int FANIN = 2
) (
    input  logic [FANIN-1:0] a,
    output logic             y
);
    import shutter_pkg::*;

    // Reject an out-of-range fan-in at elaboration by building no gate.
    generate
        if (FANIN >= NOR_MIN_FANIN && FANIN <= NOR_MAX_FANIN) begin : g_ok
            // Output is high only when every input is low.
            always_comb begin
                y = ~(|a);
            end
        end else begin : g_bad
            initial $error("nor_gate: fan-in %0d not supported", FANIN);
            always_comb y = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/inv_gate.sv
// Module: inv_gate
// Purpose: inverter built as a two-input NOR with both inputs tied together.
// Assumes: nothing beyond a valid logic level on a.
module inv_gate (
    input  logic a,
    output logic y
);
    nor_gate #(.FANIN(2)) u_nor (
        .a ({a, a}),
        .y (y)
    );

    // Inverted output must differ from input once settled.
    always_comb begin
        inv_polarity_chk: assert (y !== a || $isunknown(a))
            else $error("inv_gate: output equals input");
    end

endmodule

// File: rtl/shutter_leg.sv
// Module: shutter_leg
// Purpose: drive decision for one motor direction: own button held,
//          opposite button released, own end sensor clear.
// Assumes: inputs are settled logic levels, active high.
module shutter_leg (
    input  logic own_btn,
    input  logic other_btn,
    input  logic limit,
    output logic drive
);
    logic own_btn_n;

    inv_gate u_inv (
        .a (own_btn),
        .y (own_btn_n)
    );

    nor_gate #(.FANIN(3)) u_nor (
        .a ({own_btn_n, other_btn, limit}),
        .y (drive)
    );

    // End-sensor block for this direction.
    always_comb begin
        // R5 R6
        limit_block_chk: assert (!(limit === 1'b1 && drive === 1'b1))
            else $error("shutter_leg: drive active at end sensor");
    end

endmodule

// File: rtl/shutter_interlock.sv
// Module: shutter_interlock
// Purpose: combinational interlock for a two-direction shutter motor.
// Assumes: no clock or reset; buttons and sensors are already debounced.
module shutter_interlock (
    input  logic btn_up,
    input  logic btn_down,
    input  logic at_top,
    input  logic at_bottom,
    output logic drive_raise,
    output logic drive_lower
);
    import shutter_pkg::*;

    logic [NUM_DIRS-1:0] btn_vec;
    logic [NUM_DIRS-1:0] lim_vec;
    logic [NUM_DIRS-1:0] drv_vec;

    // Gather per-direction inputs into vectors indexed by direction.
    always_comb begin
        btn_vec[DIR_RAISE] = btn_up;
        btn_vec[DIR_LOWER] = btn_down;
        lim_vec[DIR_RAISE] = at_top;
        lim_vec[DIR_LOWER] = at_bottom;
    end

    // One mirrored leg per direction, each inhibited by the other button.
    generate
        for (genvar d = 0; d < NUM_DIRS; d++) begin : g_leg
            shutter_leg u_leg (
                .own_btn   (btn_vec[d]),
                .other_btn (btn_vec[NUM_DIRS-1-d]),
                .limit     (lim_vec[d]),
                .drive     (drv_vec[d])
            );
        end
    endgenerate

    // Map the direction vector back onto the named outputs.
    always_comb begin
        drive_raise = drv_vec[DIR_RAISE];
        drive_lower = drv_vec[DIR_LOWER];
    end

    // Safety checks on the settled outputs.
    always_comb begin
        // R8
        excl_chk: assert (!(drive_raise === 1'b1 && drive_lower === 1'b1))
            else $error("interlock: both drives active");
        // R7
        sensor_fault_chk: assert (!(at_top === 1'b1 && at_bottom === 1'b1)
                                  || (drive_raise !== 1'b1 && drive_lower !== 1'b1))
            else $error("interlock: drive during sensor fault");
        // R4
        chord_chk: assert (!(btn_up === 1'b1 && btn_down === 1'b1)
                           || (drive_raise !== 1'b1 && drive_lower !== 1'b1))
            else $error("interlock: drive with both buttons held");
        // R3
        idle_chk: assert (!(btn_up === 1'b0 && btn_down === 1'b0)
                          || (drive_raise !== 1'b1 && drive_lower !== 1'b1))
            else $error("interlock: drive with no button held");
    end

endmodule

// File: tb/shutter_interlock_tb_top.sv
module shutter_interlock_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_up, btn_down, at_top, at_bottom;
    logic drive_raise, drive_lower;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shutter_interlock dut_i (
        .btn_up      (btn_up),
        .btn_down    (btn_down),
        .at_top      (at_top),
        .at_bottom   (at_bottom),
        .drive_raise (drive_raise),
        .drive_lower (drive_lower)
    );

    // Behavioural model written from the requirements.
    function automatic logic [1:0] model(input logic [3:0] v);
        logic up, dn, top, bot, r, l;
        {up, dn, top, bot} = v;
        r = 1'b0;
        l = 1'b0;
        if (!(top && bot) && (up != dn)) begin
            r = up && !top;
            l = dn && !bot;
        end
        return {r, l};
    endfunction

    // Drive {up, down, top, bottom} on a falling edge; outputs settle before the rising edge.
    task automatic apply(input logic [3:0] v);
        @(negedge clk);
        {btn_up, btn_down, at_top, at_bottom} = v;
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] exp);
        n_checks++;
        if ({drive_raise, drive_lower} !== exp) begin
            n_fails++;
            $display("FAIL %s inputs=%b%b%b%b actual=%b%b expected=%b",
                     req, btn_up, btn_down, at_top, at_bottom,
                     drive_raise, drive_lower, exp);
        end
    endtask

    task automatic t_idle();           // R3
        for (int s = 0; s < 4; s++) begin
            apply({2'b00, s[1:0]});
            check("R3", 2'b00);
        end
    endtask

    task automatic t_raise();          // R1
        apply(4'b1000); check("R1", 2'b10);
        apply(4'b1001); check("R1", 2'b10);
    endtask

    task automatic t_lower();          // R2
        apply(4'b0100); check("R2", 2'b01);
        apply(4'b0110); check("R2", 2'b01);
    endtask

    task automatic t_chord();          // R4
        for (int s = 0; s < 4; s++) begin
            apply({2'b11, s[1:0]});
            check("R4", 2'b00);
        end
    endtask

    task automatic t_top_limit();      // R5
        apply(4'b1010); check("R5", 2'b00);
        apply(4'b1000); check("R5", 2'b10);
        apply(4'b1010); check("R5", 2'b00);
    endtask

    task automatic t_bottom_limit();   // R6
        apply(4'b0101); check("R6", 2'b00);
        apply(4'b0100); check("R6", 2'b01);
        apply(4'b0101); check("R6", 2'b00);
    endtask

    task automatic t_fault();          // R7
        for (int b = 0; b < 4; b++) begin
            apply({b[1:0], 2'b11});
            check("R7", 2'b00);
        end
    endtask

    task automatic t_sweep_up();       // R8, model match
        for (int v = 0; v < 16; v++) begin
            apply(v[3:0]);
            check("R8", model(v[3:0]));
            n_checks++;
            if (drive_raise === 1'b1 && drive_lower === 1'b1) begin
                n_fails++;
                $display("FAIL R8 inputs=%b actual=11 expected=not 11", v[3:0]);
            end
        end
    endtask

    task automatic t_sweep_down();     // R9: reverse order, same answers
        for (int v = 15; v >= 0; v--) begin
            apply(v[3:0]);
            check("R9", model(v[3:0]));
        end
    endtask

    initial begin
        {btn_up, btn_down, at_top, at_bottom} = 4'b0000;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R3", 2'b00);            // initial state, nothing pressed
        t_idle();
        t_raise();
        t_lower();
        t_chord();
        t_top_limit();
        t_bottom_limit();
        t_fault();
        t_sweep_up();
        t_sweep_down();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

endmodule